// File: doc/BRIEF.md
# Radio packet framer with CRC

This block assembles and serialises one transmit frame for a short-burst radio link. A start pulse latches the frame settings and the address, and the block then reads the payload bytes from an external byte store, one read per byte. It sends, one bit per bit-enable tick, a one-byte preamble, the address, an optional control field, the payload and an optional CRC. A done pulse marks the last bit. The block tracks a 2-bit packet identity that advances only when a fresh payload is framed.

The payload store is read through an asynchronous port: the block presents `rd_addr_o` from a register, and `rd_data_i` must show that byte in the same cycle. Every bit is MSB first within its byte. The address goes out from its most significant used byte down. Modulation, clock recovery and receive-side parsing belong to other blocks.

Top module: `pkt_framer`

## Requirements
- R1: The first 8 bits of a frame are a preamble. The preamble is 10101010 when the first address bit sent is 1, and 01010101 when that bit is 0.
- R2: Address width code 01, 10 and 11 sends 3, 4 or 5 bytes. The bytes are the least significant bytes of `addr_i[39:0]`, sent from the most significant used byte down, each byte MSB first.
- R3: A start with address width code 00 is ignored: `busy_o` stays low, and no bit, no done pulse and no packet identity change follow.
- R4: With `dyn_len_i`=1, a 9-bit control field follows the address. It holds the 6-bit payload length (MSB first), then the 2-bit packet identity (MSB first), then `no_ack_i`. With `dyn_len_i`=0 the field is left out.
- R5: The payload length n is `pld_len_i`, with values above 32 treated as 32. The payload bytes are read at `rd_addr_o` = 0..n-1 and sent unmodified. n=0 sends no payload bits.
- R6: When CRC is on, `crc_two_i`=0 appends an 8-bit CRC (x^8+x^2+x+1, start 0xFF) and `crc_two_i`=1 appends a 16-bit CRC (x^16+x^12+x^5+1, start 0xFFFF). The CRC is updated bit by bit, MSB first, over the address, the control field and the payload but not the preamble, and is sent MSB first. With `crc_en_i`=0 and `aa_any_i`=0 no CRC bits are sent.
- R7: `aa_any_i`=1 turns CRC on even when `crc_en_i`=0.
- R8: The packet identity is 0 after reset. An accepted start with `new_pld_i`=1 advances it by one (mod 4) before the frame; with `new_pld_i`=0 the previous value is reused.
- R9: Each cycle with `bit_en_i`=1 while busy yields exactly one bit: `bit_vld_o` is high for one cycle in the next cycle, with the bit on `bit_o`. No bit appears without a tick.
- R10: `done_o` is high for one cycle, in the same cycle as the last bit's `bit_vld_o`, and `busy_o` is low in that cycle.
- R11: A start pulse while busy is ignored. The running frame is unchanged and the packet identity does not advance.
- R12: After reset `busy_o`, `bit_vld_o` and `done_o` are low and `rd_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a frame (taken only when idle) |
| bit_en_i | input | 1 | Bit tick: emit one bit |
| aw_code_i | input | 2 | Address width code (01/10/11 = 3/4/5 bytes) |
| dyn_len_i | input | 1 | Include the 9-bit control field |
| no_ack_i | input | 1 | No-ack flag for the control field |
| crc_en_i | input | 1 | CRC enable |
| crc_two_i | input | 1 | 0: 8-bit CRC, 1: 16-bit CRC |
| aa_any_i | input | 1 | Auto-acknowledge on for some pipe; forces CRC |
| new_pld_i | input | 1 | Payload is new; advance packet identity |
| addr_i | input | 40 | Address, used bytes in the low end |
| pld_len_i | input | 6 | Payload length in bytes |
| rd_addr_o | output | 5 | Payload byte index to read |
| rd_data_i | input | 8 | Payload byte at `rd_addr_o`, same cycle |
| bit_o | output | 1 | Serial bit |
| bit_vld_o | output | 1 | `bit_o` is valid this cycle |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Last bit of frame |

## Verification
The hardest states to reach are the segment hand-offs. From the address or the control field the block can go straight to the CRC, or straight to done, when the payload is empty or the CRC is off. The CRC must then be loaded from the value that already includes the bit shifted in that same cycle. The bench sweeps every address width, both control-field settings, four CRC settings and payload lengths 0, 1, 7, 32 and 45, with tick spacings of 1 to 3 cycles, so every hand-off is hit under both back-to-back and sparse ticks. A start pulse injected mid-frame and a start with the illegal width code are then shown to leave the following frames' packet identity unchanged.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_PRE  = 3'd1,
        S_ADDR = 3'd2,
        S_CTRL = 3'd3,
        S_PLD  = 3'd4,
        S_CRC  = 3'd5
    } seg_e;

    localparam logic [7:0] PRE_ONE  = 8'hAA;
    localparam logic [7:0] PRE_ZERO = 8'h55;

endpackage

// File: rtl/pf_crc.sv
module pf_crc #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = W'(8'h07),
    parameter logic [W-1:0] INIT = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_nx_o
);

    logic [W-1:0] crc_q, crc_d;
    logic         fb;
    logic [W-1:0] stepped;

    always_comb begin
        fb      = crc_q[W-1] ^ bit_i;
        stepped = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        crc_d   = crc_q;
        if (init_i)    crc_d = INIT;
        else if (en_i) crc_d = stepped;
        crc_nx_o = stepped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    // R6: the register only moves on a start or on a covered bit
    p_crc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !en_i) |=> $stable(crc_q));

endmodule

// File: rtl/pf_seq.sv
module pf_seq
    import pf_pkg::*;
#(
    parameter int MAX_BYTES = 32,
    parameter int ADDR_MAX  = 5,
    parameter int LEN_W     = 6,
    parameter int PID_W     = 2,
    parameter int C8_W      = 8,
    parameter int C16_W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       bit_en_i,
    input  logic [1:0]                 aw_code_i,
    input  logic                       dyn_len_i,
    input  logic                       no_ack_i,
    input  logic                       crc_on_i,
    input  logic                       crc_two_i,
    input  logic                       new_pld_i,
    input  logic [8*ADDR_MAX-1:0]      addr_i,
    input  logic [LEN_W-1:0]           pld_len_i,
    output logic [$clog2(MAX_BYTES)-1:0] rd_addr_o,
    input  logic [7:0]                 rd_data_i,
    input  logic [C8_W-1:0]            crc8_nx_i,
    input  logic [C16_W-1:0]           crc16_nx_i,
    output logic                       crc_init_o,
    output logic                       crc_en_o,
    output logic                       crc_bit_o,
    output logic                       bit_o,
    output logic                       bit_vld_o,
    output logic                       done_o,
    output logic                       busy_o
);

    localparam int IDX_W  = $clog2(MAX_BYTES);
    localparam int SH_W   = 8 * ADDR_MAX;
    localparam int CNT_W  = $clog2(SH_W + 1);
    localparam int NAB_W  = $clog2(ADDR_MAX + 1);
    localparam int CTL_W  = LEN_W + PID_W + 1;

    typedef struct packed {
        seg_e              st;
        logic [SH_W-1:0]   sh;
        logic [SH_W-1:0]   adr;
        logic [CNT_W-1:0]  left;
        logic [NAB_W-1:0]  nab;
        logic [LEN_W-1:0]  pidx;
        logic [LEN_W-1:0]  plen;
        logic              dyn;
        logic              noack;
        logic              crc_on;
        logic              crc_two;
        logic [PID_W-1:0]  pid;
        logic              dout;
        logic              vld;
        logic              done;
    } fr_t;

    fr_t cur_q, nxt_d;

    logic             busy, tick, in_data, more_pld;
    seg_e             go;
    logic [NAB_W-1:0] nbytes;
    logic [LEN_W-1:0] len_cl;
    logic [SH_W-1:0]  aligned;
    int               shamt;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.vld  = 1'b0;
        nxt_d.done = 1'b0;
        crc_init_o = 1'b0;
        crc_en_o   = 1'b0;
        go         = S_IDLE;

        busy     = (cur_q.st != S_IDLE);
        tick     = bit_en_i && busy;
        in_data  = (cur_q.st == S_ADDR) || (cur_q.st == S_CTRL) || (cur_q.st == S_PLD);
        more_pld = (cur_q.pidx < cur_q.plen);

        nbytes  = NAB_W'(aw_code_i) + NAB_W'(2);
        len_cl  = (pld_len_i > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : pld_len_i;
        shamt   = 8 * (ADDR_MAX - int'(nbytes));
        aligned = addr_i << shamt;

        if (cur_q.st == S_IDLE) begin
            if (start_i && (aw_code_i != 2'b00)) begin
                nxt_d.st      = S_PRE;
                nxt_d.adr     = aligned;
                nxt_d.sh      = {(aligned[SH_W-1] ? PRE_ONE : PRE_ZERO), {(SH_W-8){1'b0}}};
                nxt_d.left    = CNT_W'(8);
                nxt_d.nab     = nbytes;
                nxt_d.pidx    = '0;
                nxt_d.plen    = len_cl;
                nxt_d.dyn     = dyn_len_i;
                nxt_d.noack   = no_ack_i;
                nxt_d.crc_on  = crc_on_i;
                nxt_d.crc_two = crc_two_i;
                nxt_d.pid     = new_pld_i ? cur_q.pid + PID_W'(1) : cur_q.pid;
                crc_init_o    = 1'b1;
            end
        end else if (tick) begin
            nxt_d.dout = cur_q.sh[SH_W-1];
            nxt_d.vld  = 1'b1;
            nxt_d.sh   = {cur_q.sh[SH_W-2:0], 1'b0};
            nxt_d.left = cur_q.left - CNT_W'(1);
            crc_en_o   = in_data;
            if (cur_q.left == CNT_W'(1)) begin
                unique case (cur_q.st)
                    S_PRE:  go = S_ADDR;
                    S_ADDR: go = cur_q.dyn ? S_CTRL :
                                 (more_pld ? S_PLD : (cur_q.crc_on ? S_CRC : S_IDLE));
                    S_CTRL,
                    S_PLD:  go = more_pld ? S_PLD : (cur_q.crc_on ? S_CRC : S_IDLE);
                    default: go = S_IDLE;
                endcase
                nxt_d.st = go;
                unique case (go)
                    S_ADDR: begin
                        nxt_d.sh   = cur_q.adr;
                        nxt_d.left = CNT_W'({cur_q.nab, 3'b000});
                    end
                    S_CTRL: begin
                        nxt_d.sh   = {cur_q.plen, cur_q.pid, cur_q.noack, {(SH_W-CTL_W){1'b0}}};
                        nxt_d.left = CNT_W'(CTL_W);
                    end
                    S_PLD: begin
                        nxt_d.sh   = {rd_data_i, {(SH_W-8){1'b0}}};
                        nxt_d.left = CNT_W'(8);
                        nxt_d.pidx = cur_q.pidx + LEN_W'(1);
                    end
                    S_CRC: begin
                        if (cur_q.crc_two) begin
                            nxt_d.sh   = {crc16_nx_i, {(SH_W-C16_W){1'b0}}};
                            nxt_d.left = CNT_W'(C16_W);
                        end else begin
                            nxt_d.sh   = {crc8_nx_i, {(SH_W-C8_W){1'b0}}};
                            nxt_d.left = CNT_W'(C8_W);
                        end
                    end
                    default: begin
                        nxt_d.done = 1'b1;
                        nxt_d.left = '0;
                    end
                endcase
            end
        end

        crc_bit_o = cur_q.sh[SH_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= S_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rd_addr_o = cur_q.pidx[IDX_W-1:0];
    assign bit_o     = cur_q.dout;
    assign bit_vld_o = cur_q.vld;
    assign done_o    = cur_q.done;
    assign busy_o    = busy;

    // R9: a bit only follows a tick seen while busy
    p_bit_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_o |-> $past(bit_en_i));

    // R10: done marks the last bit and the block is idle again
    p_done_with_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (bit_vld_o && !busy_o));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: illegal width code never starts a frame
    p_bad_code_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (aw_code_i == 2'b00)) |=> !busy_o);

    // R11: start while busy leaves the packet identity alone
    p_busy_start_pid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (cur_q.pid == $past(cur_q.pid)));

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
    parameter int MAX_BYTES = 32,
    parameter int ADDR_MAX  = 5,
    parameter int LEN_W     = 6,
    parameter int PID_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         bit_en_i,
    input  logic [1:0]                   aw_code_i,
    input  logic                         dyn_len_i,
    input  logic                         no_ack_i,
    input  logic                         crc_en_i,
    input  logic                         crc_two_i,
    input  logic                         aa_any_i,
    input  logic                         new_pld_i,
    input  logic [8*ADDR_MAX-1:0]        addr_i,
    input  logic [LEN_W-1:0]             pld_len_i,
    output logic [$clog2(MAX_BYTES)-1:0] rd_addr_o,
    input  logic [7:0]                   rd_data_i,
    output logic                         bit_o,
    output logic                         bit_vld_o,
    output logic                         busy_o,
    output logic                         done_o
);

    localparam int C8_W  = 8;
    localparam int C16_W = 16;

    logic              crc_on;
    logic              crc_init, crc_en, crc_bit;
    logic [C8_W-1:0]   crc8_nx;
    logic [C16_W-1:0]  crc16_nx;

    assign crc_on = crc_en_i | aa_any_i;

    pf_crc #(.W(C8_W), .POLY(8'h07), .INIT(8'hFF)) u_crc8 (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (crc_init),
        .en_i     (crc_en),
        .bit_i    (crc_bit),
        .crc_nx_o (crc8_nx)
    );

    pf_crc #(.W(C16_W), .POLY(16'h1021), .INIT(16'hFFFF)) u_crc16 (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (crc_init),
        .en_i     (crc_en),
        .bit_i    (crc_bit),
        .crc_nx_o (crc16_nx)
    );

    pf_seq #(
        .MAX_BYTES (MAX_BYTES),
        .ADDR_MAX  (ADDR_MAX),
        .LEN_W     (LEN_W),
        .PID_W     (PID_W),
        .C8_W      (C8_W),
        .C16_W     (C16_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .bit_en_i   (bit_en_i),
        .aw_code_i  (aw_code_i),
        .dyn_len_i  (dyn_len_i),
        .no_ack_i   (no_ack_i),
        .crc_on_i   (crc_on),
        .crc_two_i  (crc_two_i),
        .new_pld_i  (new_pld_i),
        .addr_i     (addr_i),
        .pld_len_i  (pld_len_i),
        .rd_addr_o  (rd_addr_o),
        .rd_data_i  (rd_data_i),
        .crc8_nx_i  (crc8_nx),
        .crc16_nx_i (crc16_nx),
        .crc_init_o (crc_init),
        .crc_en_o   (crc_en),
        .crc_bit_o  (crc_bit),
        .bit_o      (bit_o),
        .bit_vld_o  (bit_vld_o),
        .done_o     (done_o),
        .busy_o     (busy_o)
    );

endmodule

// File: tb/tb_pkt_framer.sv
module tb_pkt_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        bit_en_i = 1'b0;
    logic [1:0]  aw_code_i = 2'b11;
    logic        dyn_len_i = 1'b0;
    logic        no_ack_i = 1'b0;
    logic        crc_en_i = 1'b0;
    logic        crc_two_i = 1'b0;
    logic        aa_any_i = 1'b0;
    logic        new_pld_i = 1'b0;
    logic [39:0] addr_i = '0;
    logic [5:0]  pld_len_i = '0;
    logic [4:0]  rd_addr_o;
    logic [7:0]  rd_data_i;
    logic        bit_o, bit_vld_o, busy_o, done_o;

    logic [7:0]  mem [0:31];

    always #5 clk = ~clk;

    assign rd_data_i = mem[rd_addr_o];

    pkt_framer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_en_i(bit_en_i),
        .aw_code_i(aw_code_i), .dyn_len_i(dyn_len_i), .no_ack_i(no_ack_i),
        .crc_en_i(crc_en_i), .crc_two_i(crc_two_i), .aa_any_i(aa_any_i),
        .new_pld_i(new_pld_i), .addr_i(addr_i), .pld_len_i(pld_len_i),
        .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .bit_o(bit_o),
        .bit_vld_o(bit_vld_o), .busy_o(busy_o), .done_o(done_o)
    );

    int checks = 0;
    int fails  = 0;

    bit          exp_b [0:511];
    bit          got_b [0:511];
    int          n_exp, n_got;
    int          o_addr, o_ctrl, o_pld, o_crc;
    logic [15:0] exp_crc;
    int          pid_model = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input bit b, input bit two);
        logic fb;
        if (two) begin
            fb = c[15] ^ b;
            return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        fb = c[7] ^ b;
        return {8'h00, c[6:0], 1'b0} ^ (fb ? 16'h0007 : 16'h0000);
    endfunction

    task automatic push(input bit v, input bit cov, input bit two);
        exp_b[n_exp] = v;
        n_exp++;
        if (cov) exp_crc = crc_step(exp_crc, v, two);
    endtask

    task automatic build(input int aw, input int dyn, input int na, input int crcon,
                         input int two, input int len, input int pid, input logic [39:0] a);
        int nb;
        int pl;
        bit first;
        nb = aw + 2;
        pl = (len > 32) ? 32 : len;
        exp_crc = two ? 16'hFFFF : 16'h00FF;
        n_exp = 0;
        first = a[8*nb-1];
        for (int i = 0; i < 8; i++) push(first ? (i % 2 == 0) : (i % 2 == 1), 1'b0, two[0]);
        o_addr = n_exp;
        for (int b = nb - 1; b >= 0; b--)
            for (int k = 7; k >= 0; k--) push(a[8*b+k], 1'b1, two[0]);
        o_ctrl = n_exp;
        if (dyn != 0) begin
            for (int k = 5; k >= 0; k--) push(pl[k], 1'b1, two[0]);
            push(pid[1], 1'b1, two[0]);
            push(pid[0], 1'b1, two[0]);
            push(na[0], 1'b1, two[0]);
        end
        o_pld = n_exp;
        for (int by = 0; by < pl; by++)
            for (int k = 7; k >= 0; k--) push(mem[by][k], 1'b1, two[0]);
        o_crc = n_exp;
        if (crcon != 0) begin
            if (two != 0) begin
                for (int k = 15; k >= 0; k--) push(exp_crc[k], 1'b0, two[0]);
            end else begin
                for (int k = 7; k >= 0; k--) push(exp_crc[k], 1'b0, two[0]);
            end
        end
    endtask

    task automatic cmp_seg(input string req, input string what, input int lo, input int n);
        int bad;
        int act;
        int expv;
        bad = -1;
        act = 0;
        expv = 0;
        for (int i = lo; i < lo + n; i++) begin
            if (bad < 0 && (i >= n_got || got_b[i] != exp_b[i])) begin
                bad = i;
                act = (i < n_got) ? int'(got_b[i]) : -1;
                expv = int'(exp_b[i]);
            end
        end
        chk(bad < 0, req, $sformatf("%s first bad bit %0d", what, bad), act, expv);
    endtask

    task automatic run_frame(input int aw, input int dyn, input int na, input int cen,
                             input int aa, input int two, input int len, input int newp,
                             input int per, input int fr, input bit poke);
        int cyc;
        int ndone;
        int donebad;
        int badtick;
        bit fin;
        logic [39:0] a;
        a = (40'(fr) * 40'h9E3779B97) ^ 40'h5A_C3_1E_87_F0;
        for (int i = 0; i < 32; i++) mem[i] = 8'(i * 29 + fr * 7 + 3);
        if (newp != 0) pid_model = (pid_model + 1) % 4;
        build(aw, dyn, na, ((cen != 0) || (aa != 0)) ? 1 : 0, two, len, pid_model, a);
        aw_code_i = 2'(aw); dyn_len_i = dyn[0]; no_ack_i = na[0]; crc_en_i = cen[0];
        aa_any_i = aa[0]; crc_two_i = two[0]; pld_len_i = 6'(len); new_pld_i = newp[0];
        addr_i = a;
        start_i = 1'b1;
        bit_en_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0; ndone = 0; donebad = 0; badtick = 0; fin = 1'b0; n_got = 0;
        while (!fin && cyc < 3000) begin
            bit_en_i = ((cyc % per) == 0);
            if (poke && cyc == 20) begin
                start_i = 1'b1;
                new_pld_i = 1'b1;
                aw_code_i = 2'b01;
            end
            @(negedge clk);
            start_i = 1'b0;
            if (bit_vld_o) begin
                if (n_got < 512) got_b[n_got] = bit_o;
                n_got++;
                if (!bit_en_i) badtick++;
            end
            if (done_o) begin
                ndone++;
                if (!bit_vld_o || busy_o) donebad++;
                fin = 1'b1;
            end
            cyc++;
        end
        bit_en_i = 1'b0;
        chk(fin, "R10", "frame finished within 3000 cycles", longint'(fin), 1);
        chk(n_got == n_exp, "R9", "bit count", n_got, n_exp);
        chk(badtick == 0, "R9", "bits without tick", badtick, 0);
        chk(ndone == 1 && donebad == 0, "R10", "done pulse with last bit", donebad, 0);
        cmp_seg("R1", "preamble", 0, 8);
        cmp_seg("R2", "address", o_addr, o_ctrl - o_addr);
        if (dyn != 0) begin
            cmp_seg("R4", "control field", o_ctrl, 9);
            chk(n_got > o_ctrl + 7 && {got_b[o_ctrl+6], got_b[o_ctrl+7]} == 2'(pid_model),
                "R8", "packet identity",
                (n_got > o_ctrl + 7) ? longint'({got_b[o_ctrl+6], got_b[o_ctrl+7]}) : -1,
                pid_model);
        end
        if (o_crc > o_pld) cmp_seg("R5", "payload", o_pld, o_crc - o_pld);
        if (n_exp > o_crc) cmp_seg((aa != 0 && cen == 0) ? "R7" : "R6", "crc", o_crc, n_exp - o_crc);
        else chk(n_got == o_crc, "R6", "no crc bits when off", n_got, o_crc);
        if (poke) chk(ndone == 1 && n_got == n_exp, "R11", "start while busy ignored", n_got, n_exp);
    endtask

    task automatic run_illegal();
        int seen;
        aw_code_i = 2'b00;
        new_pld_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen = 0;
        for (int c = 0; c < 40; c++) begin
            bit_en_i = 1'b1;
            @(negedge clk);
            if (busy_o || bit_vld_o || done_o) seen++;
        end
        bit_en_i = 1'b0;
        chk(seen == 0, "R3", "activity after illegal width start", seen, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lens [5];
        int fr;
        lens = '{0, 1, 7, 32, 45};
        for (int i = 0; i < 32; i++) mem[i] = 8'(i);
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!busy_o && !bit_vld_o && !done_o && rd_addr_o == 5'd0, "R12", "reset outputs",
            longint'({busy_o, bit_vld_o, done_o, rd_addr_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !bit_vld_o && !done_o, "R12", "idle after reset release",
            longint'({busy_o, bit_vld_o, done_o}), 0);
        run_illegal();
        fr = 0;
        for (int aw = 1; aw <= 3; aw++)
            for (int dyn = 0; dyn < 2; dyn++)
                for (int cm = 0; cm < 4; cm++)
                    for (int li = 0; li < 5; li++) begin
                        run_frame(aw, dyn, (fr / 2) % 2,
                                  (cm == 1 || cm == 2) ? 1 : 0,
                                  (cm == 3) ? 1 : 0,
                                  (cm == 2 || (cm == 3 && fr % 2 == 1)) ? 1 : 0,
                                  lens[li], (fr % 3 != 1) ? 1 : 0,
                                  1 + fr % 3, fr, (fr % 17 == 5));
                        if (fr == 40) run_illegal();
                        fr++;
                    end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule